// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the hardware that moves a processor into and out of an interrupt handler. When a request is accepted, it stores eight context words as one frame on the active stack through a word-wide memory port. It then fetches the handler address from a vector table and produces a link code. That code records whether the interrupted code was a handler or thread code, and which stack thread code used. Finally the block switches to handler mode on the main stack. When a handler branches to one of the link codes, the sequencer reads the frame back and restores the mode and the stack pointer that the code selects.

Two shortcuts remove memory traffic. When a return arrives while another request is pending, the sequencer skips both the unstacking and the restacking and goes straight to the vector fetch. This is tail-chaining. When a more urgent request number appears while the frame is still being written, the frame is written only once and the vector of the newer number is fetched. The less urgent request can be tail-chained later. Prioritisation, instruction fetch and decode stay outside the block. The register values to save arrive on an input bus, and the restored values leave on an output bus.

Top module: `exc_seq`

## Requirements
- R1: After reset the block is idle, in thread mode, using the main stack, with `msp_q` = `MSP_RESET`, `psp_q` = `PSP_RESET`, `mem_req` low and both done pulses low.
- R2: An accepted request writes 8 words. Word k of `ctx_in` (bits 32k+31..32k, in the order R0, R1, R2, R3, R12, LR, return PC, status word) goes to address SP-32+4k. SP is the process stack pointer in thread mode with `psp_active` high, and the main stack pointer otherwise. That pointer ends 32 lower.
- R3: After stacking, the word at `VTOR_BASE` + 4*(irq number + 16) is read. `entry_done` pulses for one cycle with `pc_out` equal to that word and `vec_irq` equal to the number used.
- R4: `lr_out` is 0xFFFFFFF1 when entry came from handler mode, 0xFFFFFFF9 from thread mode on the main stack, and 0xFFFFFFFD from thread mode on the process stack.
- R5: When `entry_done` pulses, `handler_mode` is high and `psp_active` is low.
- R6: In handler mode with no request pending, `ret_valid` with one of the three codes reads 8 words upward from the selected stack (the process stack for 0xFFFFFFFD, the main stack otherwise). `ret_done` then pulses with `ctx_out` holding the words in R2 order, `pc_out` equal to word 6, and that stack pointer raised by 32. The mode becomes handler for 0xFFFFFFF1 and thread otherwise, with `psp_active` high only for 0xFFFFFFFD.
- R7: `ret_valid` with any other target value, or while in thread mode, is ignored. No memory access is made, no done pulse occurs, and the mode and pointers are unchanged.
- R8: A valid return seen while `irq_req` is high performs no writes, exactly one read (the vector), and no pointer change. `entry_done` pulses with `lr_out` equal to the return code presented.
- R9: With `LATE_REDIRECT` = 1, the irq number is sampled in the cycle in which the last frame word is written. A number changed during stacking therefore gets its vector, and stacking is not repeated (still 8 writes).
- R10: An access completes only in a cycle with `mem_ready` high. While stalled, `mem_req`, `mem_we` and `mem_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | A request is pending |
| irq_num | input | IRQ_W | Number of the most urgent pending request |
| ret_valid | input | 1 | A branch target is presented for return check |
| ret_target | input | 32 | Branch target value |
| ctx_in | input | 256 | Eight context words to save, word k at bits 32k+31..32k |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| entry_done | output | 1 | One-cycle pulse: handler entry complete |
| ret_done | output | 1 | One-cycle pulse: return complete |
| pc_out | output | 32 | Handler address or restored PC |
| lr_out | output | 32 | Link code produced on entry |
| vec_irq | output | IRQ_W | Irq number whose vector was fetched |
| handler_mode | output | 1 | Handler mode active |
| psp_active | output | 1 | Thread code uses the process stack |
| msp_q | output | AW | Main stack pointer |
| psp_q | output | AW | Process stack pointer |
| ctx_out | output | 256 | Restored context words, same layout as ctx_in |

## Verification
Several properties are checked on every cycle by the assertions. The two done pulses are never high together. Every entry leaves handler mode on the main stack with a legal link code. A stalled access keeps its request, direction and address. Each completed return moves exactly one stack pointer up by one frame. Other behaviours can only be shown by the bench's scenarios, which compare results against a model of memory and pointers. These are the frame's word order and placement, the vector address, the choice of stack for each link code, that invalid returns are ignored, the tail-chain path's lack of frame traffic, and the late switch of the irq number during stacking.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
   localparam int DW          = 32;
   localparam int FRAME_WORDS = 8;
   localparam int VEC_BIAS    = 16;
   localparam logic [DW-1:0] LNK_HANDLER = 32'hFFFF_FFF1;
   localparam logic [DW-1:0] LNK_THR_MSP = 32'hFFFF_FFF9;
   localparam logic [DW-1:0] LNK_THR_PSP = 32'hFFFF_FFFD;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PUSH = 2'd1,
      ST_VEC  = 2'd2,
      ST_POP  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
   import exc_seq_pkg::*;
(
   input  logic          cur_handler,
   input  logic          cur_psp,
   input  logic [DW-1:0] ret_target,
   output logic [DW-1:0] entry_code,
   output logic          tgt_valid,
   output logic          tgt_handler,
   output logic          tgt_psp
);
   always_comb begin
      if (cur_handler)  entry_code = LNK_HANDLER;
      else if (cur_psp) entry_code = LNK_THR_PSP;
      else              entry_code = LNK_THR_MSP;
   end

   assign tgt_handler = (ret_target == LNK_HANDLER);
   assign tgt_psp     = (ret_target == LNK_THR_PSP);
   assign tgt_valid   = tgt_handler || tgt_psp || (ret_target == LNK_THR_MSP);
endmodule

// File: rtl/exc_frame_walk.sv
module exc_frame_walk #(
   parameter int AW = 32,
   parameter int NW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  step,
   input  logic [AW-1:0]         base,
   output logic [$clog2(NW)-1:0] idx,
   output logic [AW-1:0]         addr,
   output logic                  last
);
   localparam int IW = $clog2(NW);

   if (NW < 2 || (1 << IW) != NW) begin : g_bad_nw
      $error("frame word count must be a power of two");
   end

   assign last = (idx == IW'(NW - 1));
   assign addr = base + (AW'(idx) << 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx <= '0;
      else if (clr)   idx <= '0;
      else if (step)  idx <= last ? '0 : idx + 1'b1;
   end

   // R2
   walk_clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (idx == '0));
endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_seq_pkg::*;
#(
   parameter int            AW            = 32,
   parameter int            IRQ_W         = 5,
   parameter logic [AW-1:0] VTOR_BASE     = '0,
   parameter logic [AW-1:0] MSP_RESET     = AW'(32'h2000_1000),
   parameter logic [AW-1:0] PSP_RESET     = AW'(32'h2000_0800),
   parameter bit            LATE_REDIRECT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  irq_req,
   input  logic [IRQ_W-1:0]      irq_num,
   input  logic                  ret_valid,
   input  logic [DW-1:0]         ret_target,
   input  logic [FRAME_WORDS*DW-1:0] ctx_in,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [AW-1:0]         mem_addr,
   output logic [DW-1:0]         mem_wdata,
   input  logic                  mem_ready,
   input  logic [DW-1:0]         mem_rdata,
   output logic                  entry_done,
   output logic                  ret_done,
   output logic [DW-1:0]         pc_out,
   output logic [DW-1:0]         lr_out,
   output logic [IRQ_W-1:0]      vec_irq,
   output logic                  handler_mode,
   output logic                  psp_active,
   output logic [AW-1:0]         msp_q,
   output logic [AW-1:0]         psp_q,
   output logic [FRAME_WORDS*DW-1:0] ctx_out
);
   localparam int IW          = $clog2(FRAME_WORDS);
   localparam int FRAME_BYTES = FRAME_WORDS * (DW / 8);
   localparam int PC_SLOT     = 6;

   if (IRQ_W < 1 || IRQ_W > 8) begin : g_bad_irqw
      $error("IRQ_W out of range");
   end
   if (AW < 16 || AW > 32) begin : g_bad_aw
      $error("AW out of range");
   end
   if (VTOR_BASE[1:0] != 2'b00 || MSP_RESET[2:0] != 3'b000 || PSP_RESET[2:0] != 3'b000) begin : g_bad_align
      $error("base addresses must be aligned");
   end

   seq_state_e        state_q;
   logic [DW-1:0]     frame_q [FRAME_WORDS];
   logic [AW-1:0]     fbase_q;
   logic [DW-1:0]     code_q;
   logic [IRQ_W-1:0]  irq_lat_q;
   logic              pop_hnd_q;
   logic              pop_psp_q;

   logic [DW-1:0]     entry_code;
   logic              tgt_valid, tgt_handler, tgt_psp;
   logic [IW-1:0]     w_idx;
   logic [AW-1:0]     w_addr;
   logic              w_last;
   logic              hs;
   logic              use_msp;
   logic [AW-1:0]     cur_sp;
   logic              take_ret;
   logic [IRQ_W-1:0]  irq_at_last;

   exc_code_map u_code (
      .cur_handler (handler_mode),
      .cur_psp     (psp_active),
      .ret_target  (ret_target),
      .entry_code  (entry_code),
      .tgt_valid   (tgt_valid),
      .tgt_handler (tgt_handler),
      .tgt_psp     (tgt_psp)
   );

   assign hs = mem_req && mem_ready;

   exc_frame_walk #(.AW(AW), .NW(FRAME_WORDS)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == ST_IDLE),
      .step  (hs && (state_q == ST_PUSH || state_q == ST_POP)),
      .base  (fbase_q),
      .idx   (w_idx),
      .addr  (w_addr),
      .last  (w_last)
   );

   if (LATE_REDIRECT) begin : g_late
      assign irq_at_last = irq_num;
   end else begin : g_early
      assign irq_at_last = irq_lat_q;
   end

   assign use_msp  = handler_mode || !psp_active;
   assign cur_sp   = use_msp ? msp_q : psp_q;
   assign take_ret = ret_valid && tgt_valid && handler_mode;

   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_PUSH);
   assign mem_wdata = frame_q[w_idx];
   assign mem_addr  = (state_q == ST_VEC)
                      ? VTOR_BASE + ((AW'(irq_lat_q) + AW'(VEC_BIAS)) << 2)
                      : w_addr;

   for (genvar k = 0; k < FRAME_WORDS; k++) begin : g_ctx_out
      assign ctx_out[k*DW +: DW] = frame_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         fbase_q      <= '0;
         code_q       <= '0;
         irq_lat_q    <= '0;
         pop_hnd_q    <= 1'b0;
         pop_psp_q    <= 1'b0;
         entry_done   <= 1'b0;
         ret_done     <= 1'b0;
         pc_out       <= '0;
         lr_out       <= '0;
         vec_irq      <= '0;
         handler_mode <= 1'b0;
         psp_active   <= 1'b0;
         msp_q        <= MSP_RESET;
         psp_q        <= PSP_RESET;
         for (int k = 0; k < FRAME_WORDS; k++) frame_q[k] <= '0;
      end else begin
         entry_done <= 1'b0;
         ret_done   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (take_ret && irq_req) begin
                  state_q   <= ST_VEC;
                  code_q    <= ret_target;
                  irq_lat_q <= irq_num;
               end else if (take_ret) begin
                  state_q   <= ST_POP;
                  pop_hnd_q <= tgt_handler;
                  pop_psp_q <= tgt_psp;
                  fbase_q   <= tgt_psp ? psp_q : msp_q;
               end else if (irq_req) begin
                  state_q   <= ST_PUSH;
                  fbase_q   <= cur_sp - AW'(FRAME_BYTES);
                  code_q    <= entry_code;
                  irq_lat_q <= irq_num;
                  if (use_msp) msp_q <= cur_sp - AW'(FRAME_BYTES);
                  else         psp_q <= cur_sp - AW'(FRAME_BYTES);
                  for (int k = 0; k < FRAME_WORDS; k++) frame_q[k] <= ctx_in[k*DW +: DW];
               end
            end
            ST_PUSH: begin
               if (hs && w_last) begin
                  state_q   <= ST_VEC;
                  irq_lat_q <= irq_at_last;
               end
            end
            ST_VEC: begin
               if (hs) begin
                  state_q      <= ST_IDLE;
                  pc_out       <= mem_rdata;
                  lr_out       <= code_q;
                  vec_irq      <= irq_lat_q;
                  entry_done   <= 1'b1;
                  handler_mode <= 1'b1;
                  psp_active   <= 1'b0;
               end
            end
            ST_POP: begin
               if (hs) begin
                  frame_q[w_idx] <= mem_rdata;
                  if (w_last) begin
                     state_q      <= ST_IDLE;
                     pc_out       <= frame_q[PC_SLOT];
                     ret_done     <= 1'b1;
                     handler_mode <= pop_hnd_q;
                     psp_active   <= pop_psp_q;
                     if (pop_psp_q) psp_q <= fbase_q + AW'(FRAME_BYTES);
                     else           msp_q <= fbase_q + AW'(FRAME_BYTES);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R3 R6
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(entry_done && ret_done));

   // R5
   entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |-> (handler_mode && !psp_active));

   // R4
   lr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_done |-> (lr_out == LNK_HANDLER || lr_out == LNK_THR_MSP || lr_out == LNK_THR_PSP));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

   // R6
   ret_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_done |-> (psp_active ? (psp_q == $past(psp_q) + AW'(FRAME_BYTES))
                               : (msp_q == $past(msp_q) + AW'(FRAME_BYTES))));
endmodule

// File: tb/exc_seq_tb_top.sv
`timescale 1ns/1ps
module exc_seq_tb_top;
   localparam int IRQ_W = 5;
   localparam logic [31:0] MSP0 = 32'h0000_1F00;
   localparam logic [31:0] PSP0 = 32'h0000_1700;
   localparam logic [31:0] C_H  = 32'hFFFF_FFF1;
   localparam logic [31:0] C_TM = 32'hFFFF_FFF9;
   localparam logic [31:0] C_TP = 32'hFFFF_FFFD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq_req = 1'b0;
   logic [IRQ_W-1:0] irq_num = '0;
   logic ret_valid = 1'b0;
   logic [31:0] ret_target = '0;
   logic [255:0] ctx_in = '0;
   logic mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic entry_done, ret_done, handler_mode, psp_active;
   logic [31:0] pc_out, lr_out, msp_q, psp_q;
   logic [IRQ_W-1:0] vec_irq;
   logic [255:0] ctx_out;

   logic [31:0] mem_m [2048];
   int wr_cnt = 0, rd_cnt = 0;
   int total = 0, bad = 0;
   bit finished = 0;
   bit rdy_force = 0;

   bit m_h = 0, m_p = 0;
   logic [31:0] m_msp = MSP0, m_psp = PSP0;

   always #4 clk = ~clk;

   exc_seq #(.AW(32), .IRQ_W(IRQ_W), .VTOR_BASE(32'h0), .MSP_RESET(MSP0),
             .PSP_RESET(PSP0), .LATE_REDIRECT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
      .ret_valid(ret_valid), .ret_target(ret_target), .ctx_in(ctx_in),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .entry_done(entry_done), .ret_done(ret_done), .pc_out(pc_out),
      .lr_out(lr_out), .vec_irq(vec_irq), .handler_mode(handler_mode),
      .psp_active(psp_active), .msp_q(msp_q), .psp_q(psp_q), .ctx_out(ctx_out));

   assign mem_rdata = mem_m[mem_addr[12:2]];

   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         if (mem_we) begin
            mem_m[mem_addr[12:2]] = mem_wdata;
            wr_cnt++;
         end else begin
            rd_cnt++;
         end
      end
   end

   always @(negedge clk) mem_ready <= rdy_force ? 1'b1 : (($urandom % 4) != 0);

   function automatic logic [31:0] vec_val(input int n);
      return 32'h0000_8001 + (32'(n) << 8);
   endfunction

   function automatic logic [31:0] word_at(input logic [31:0] a);
      return mem_m[a[12:2]];
   endfunction

   task automatic tick;
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_entry(input int num, input logic [255:0] ctx, input int late);
      logic [31:0] sp_old, code;
      bit use_m, seen;
      int w0, eff;
      logic [255:0] got;
      use_m = m_h || !m_p;
      sp_old = use_m ? m_msp : m_psp;
      code = m_h ? C_H : (m_p ? C_TP : C_TM);
      w0 = wr_cnt;
      eff = num;
      irq_num = IRQ_W'(num);
      ctx_in = ctx;
      irq_req = 1'b1;
      seen = 0;
      for (int c = 0; c < 600 && !seen; c++) begin
         tick();
         if (late >= 0 && wr_cnt > w0 && wr_cnt < w0 + 7) begin
            irq_num = IRQ_W'(late);
            eff = late;
         end
         if (entry_done) seen = 1;
      end
      irq_req = 1'b0;
      chk(seen, "R3 entry_done pulse", 256'(entry_done), 256'(1));
      if (use_m) m_msp = sp_old - 32; else m_psp = sp_old - 32;
      chk(pc_out == vec_val(eff), "R3 handler pc", 256'(pc_out), 256'(vec_val(eff)));
      chk(vec_irq == IRQ_W'(eff), late >= 0 ? "R9 late vector number" : "R3 vector number",
          256'(vec_irq), 256'(eff));
      chk(lr_out == code, "R4 link code", 256'(lr_out), 256'(code));
      chk(handler_mode && !psp_active, "R5 handler on main stack",
          256'({handler_mode, psp_active}), 256'(2'b10));
      chk(msp_q == m_msp && psp_q == m_psp, "R2 stack pointers",
          256'({msp_q, psp_q}), 256'({m_msp, m_psp}));
      for (int k = 0; k < 8; k++) got[k*32 +: 32] = word_at(sp_old - 32 + 32'(4*k));
      chk(got == ctx, "R2 frame contents", got, ctx);
      chk(wr_cnt - w0 == 8, late >= 0 ? "R9 single stacking" : "R2 write count",
          256'(wr_cnt - w0), 256'(8));
      m_h = 1; m_p = 0;
   endtask

   task automatic do_return(input logic [31:0] code, input bit pend, input int pnum);
      logic [31:0] base;
      logic [255:0] expc;
      int w0, r0;
      bit seen_e, seen_r;
      base = (code == C_TP) ? m_psp : m_msp;
      for (int k = 0; k < 8; k++) expc[k*32 +: 32] = word_at(base + 32'(4*k));
      w0 = wr_cnt; r0 = rd_cnt;
      ret_target = code;
      ret_valid = 1'b1;
      irq_req = pend;
      irq_num = IRQ_W'(pnum);
      tick();
      ret_valid = 1'b0;
      seen_e = 0; seen_r = 0;
      for (int c = 0; c < 600 && !seen_e && !seen_r; c++) begin
         tick();
         if (entry_done) seen_e = 1;
         if (ret_done) seen_r = 1;
      end
      irq_req = 1'b0;
      if (pend) begin
         chk(seen_e && !seen_r, "R8 tail-chain entry", 256'({seen_e, seen_r}), 256'(2'b10));
         chk(lr_out == code, "R8 link kept", 256'(lr_out), 256'(code));
         chk(pc_out == vec_val(pnum), "R8 chained vector", 256'(pc_out), 256'(vec_val(pnum)));
         chk(wr_cnt == w0 && rd_cnt - r0 == 1, "R8 no frame traffic",
             256'({32'(wr_cnt - w0), 32'(rd_cnt - r0)}), 256'({32'd0, 32'd1}));
         chk(msp_q == m_msp && psp_q == m_psp, "R8 pointers unchanged",
             256'({msp_q, psp_q}), 256'({m_msp, m_psp}));
      end else begin
         chk(seen_r && !seen_e, "R6 ret_done pulse", 256'({seen_e, seen_r}), 256'(2'b01));
         chk(ctx_out == expc, "R6 restored context", ctx_out, expc);
         chk(pc_out == expc[6*32 +: 32], "R6 restored pc", 256'(pc_out), 256'(expc[6*32 +: 32]));
         chk(rd_cnt - r0 == 8 && wr_cnt == w0, "R6 read count",
             256'(rd_cnt - r0), 256'(8));
         if (code == C_TP) m_psp = base + 32; else m_msp = base + 32;
         m_h = (code == C_H);
         m_p = (code == C_TP);
         chk(handler_mode == m_h && psp_active == m_p && msp_q == m_msp && psp_q == m_psp,
             "R6 mode and pointer", 256'({handler_mode, psp_active, msp_q, psp_q}),
             256'({m_h, m_p, m_msp, m_psp}));
      end
   endtask

   task automatic do_ignored(input logic [31:0] code);
      bit any;
      ret_target = code;
      ret_valid = 1'b1;
      tick();
      ret_valid = 1'b0;
      any = 0;
      for (int c = 0; c < 10; c++) begin
         tick();
         if (mem_req || entry_done || ret_done) any = 1;
      end
      chk(!any, "R7 no activity", 256'(any), 256'(0));
      chk(handler_mode == m_h && psp_active == m_p && msp_q == m_msp && psp_q == m_psp,
          "R7 state unchanged", 256'({handler_mode, psp_active, msp_q, psp_q}),
          256'({m_h, m_p, m_msp, m_psp}));
   endtask

   function automatic logic [255:0] rnd_ctx();
      logic [255:0] v;
      for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   initial begin
      for (int i = 0; i < 2048; i++) mem_m[i] = 32'hA5A5_0000 + 32'(i);
      for (int i = 16; i < 16 + 32; i++) mem_m[i] = vec_val(i - 16);
      void'($urandom(32'd1234));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(!handler_mode && !psp_active, "R1 reset mode", 256'({handler_mode, psp_active}), 256'(0));
      chk(msp_q == MSP0 && psp_q == PSP0, "R1 reset pointers", 256'({msp_q, psp_q}), 256'({MSP0, PSP0}));
      chk(!mem_req && !entry_done && !ret_done, "R1 reset idle",
          256'({mem_req, entry_done, ret_done}), 256'(0));

      do_entry(3, {8{32'h1111_0000}} ^ 256'h0123_4567_89AB_CDEF, -1);
      do_entry(7, rnd_ctx(), -1);
      do_ignored(32'hFFFF_FFF5);
      do_return(C_H, 0, 0);
      do_return(C_TM, 1, 9);
      do_return(C_TM, 0, 0);
      do_ignored(C_TM);
      do_entry(2, rnd_ctx(), 12);
      do_return(C_TP, 0, 0);
      do_entry(5, rnd_ctx(), -1);
      rdy_force = 1;
      do_return(C_TP, 0, 0);
      rdy_force = 0;

      for (int it = 0; it < 20; it++) begin
         logic [31:0] code;
         code = m_p ? C_TP : C_TM;
         do_entry(int'($urandom % 32), rnd_ctx(), -1);
         if ($urandom % 2 == 1) do_entry(int'($urandom % 32), rnd_ctx(), -1);
         else code = 32'h0;
         if (code != 32'h0) do_return(C_H, ($urandom % 2) == 1, int'($urandom % 32));
         do_return(m_p ? C_TP : (code != 32'h0 ? code : (lr_out)), ($urandom % 3) == 0,
                   int'($urandom % 32));
         if (m_h) do_return(lr_out, 0, 0);
      end

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule